// File: doc/BRIEF.md
# Dual Reloadable Down-Counter Timer

This block holds two independent 32-bit down-counters. A simple register bus with 32-bit reads and writes reaches them. Each counter steps down by one on every cycle where the timer tick input is high and that counter is enabled. One shared control word holds an enable bit and a reload-enable bit for each counter.

When a counter reaches zero it expires. It then either reloads from its own reload register, which gives a periodic event, or stays at zero, which gives a one-shot event. Each expiry sets a flag in a cause register. A mask register chooses which flags drive a single registered interrupt output. Software can read a running timestamp by bitwise-inverting the value of a counter that runs freely from all ones.

Bus writes take effect at the clock edge where the write strobe is high. Read data is registered: it appears on the cycle after the read strobe.

Top module: `dual_dtimer`

## Requirements
- R1: After reset every register reads zero and the interrupt output is low. A read of any offset other than 0x000, 0x010, 0x014, 0x018, 0x01C, 0x110 or 0x114 returns zero.
- R2: While its enable bit is set, a counter decrements by one on each cycle where the tick is high and the counter is not zero. While its enable bit is clear, the counter holds its value.
- R3: A tick that finds an enabled counter at zero is an expiry. An expiry sets that counter's cause bit whatever the mask holds. Timer 0 owns bit 1 and timer 1 owns bit 2 of both the cause register (0x110) and the mask register (0x114).
- R4: With reload enabled, an expiry loads the counter from its reload register (timer 0 at 0x010, timer 1 at 0x018). A reload value of N-1 therefore gives one event every N ticks.
- R5: With reload disabled, the counter stays at zero after its expiry. It raises no further event until its value register is written again.
- R6: A write to a value register (timer 0 at 0x014, timer 1 at 0x01C) loads the counter at once, even while the timer is enabled. Such a write wins over a tick in the same cycle. A read of the value register returns the live count.
- R7: The cause register clears on a written 0. A written 1 leaves that bit unchanged. An expiry in the same cycle as a clear leaves the bit set.
- R8: The interrupt output is a register that takes the OR of (cause AND mask) one cycle later. Only mask bits 1 and 2 are kept; all other bits read zero.
- R9: The control word sits at 0x000. Bit 0 enables timer 0, bit 1 enables reload for timer 0, bit 2 enables timer 1 and bit 3 enables reload for timer 1. It reads back in the same layout, with the upper bits zero.
- R10: With 0xFFFFFFFF in both the reload and value registers and reload enabled, the counter runs freely. The bitwise inverse of its value equals the number of ticks since it was loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer tick enable, one count step per high cycle |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Registered interrupt request |

## Verification
The one-shot pattern runs a counter down in pieces, with a frozen stretch in between. It then keeps ticking past zero, which separates the expiry at zero from a decrement through zero and shows that an idle one-shot raises no second event. The periodic pattern uses a reload of 3 to confirm a four-tick period, and a free-running load of all ones confirms that the inverted value counts ticks. A clear written while both flags are set, with mask changes before and after, separates the two cause bits and shows how the mask gates the interrupt output. A value written in the same cycle as a tick shows that the write wins.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 12;
  localparam int NUM_TMR = 2;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_TBASE  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_TSTEP  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_VALSFT = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_CAUSE  = 12'h110;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h114;

  localparam int CAUSE_LSB = 1;
  localparam int CTRL_BITS = 2 * NUM_TMR;

  function automatic logic [ADDR_W-1:0] reload_ofs(input int idx);
    return OFS_TBASE + OFS_TSTEP * idx[ADDR_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] value_ofs(input int idx);
    return OFS_TBASE + OFS_TSTEP * idx[ADDR_W-1:0] + OFS_VALSFT;
  endfunction
endpackage

// File: rtl/dtm_counter.sv
module dtm_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         en,
  input  logic         rl_en,
  input  logic         load_wr,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt,
  output logic         expire
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         armed_q, armed_d;
  logic         cnt_ce;

  assign cnt_ce = load_wr | (en & tick);

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    expire  = 1'b0;
    if (load_wr) begin
      cnt_d   = load_val;
      armed_d = 1'b1;
    end else if (en && tick) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else if (rl_en) begin
        cnt_d  = reload_val;
        expire = 1'b1;
      end else if (armed_q) begin
        armed_d = 1'b0;
        expire  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (cnt_ce) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dtm_intc.sv
module dtm_intc #(
  parameter int NT = 2,
  parameter int W  = 32,
  parameter int LSB = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] expire,
  input  logic          cause_wr,
  input  logic          mask_wr,
  input  logic [W-1:0]  wdata,
  output logic [NT-1:0] cause,
  output logic [NT-1:0] mask,
  output logic          irq
);
  logic [NT-1:0] cause_q, cause_d, mask_q, mask_d;
  logic          irq_q, irq_d;
  logic          cause_ce;

  assign cause_ce = cause_wr | (|expire);

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      cause_d[i] = expire[i] | (cause_q[i] & ~(cause_wr & ~wdata[LSB+i]));
      mask_d[i]  = wdata[LSB+i];
    end
    irq_d = |(cause_q & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (cause_ce) begin
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_wr) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign cause = cause_q;
  assign mask  = mask_q;
  assign irq   = irq_q;
endmodule

// File: rtl/dtm_regs.sv
module dtm_regs
  import dtm_pkg::*;
#(
  parameter int NT = NUM_TMR,
  parameter int W  = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [AW-1:0]       bus_addr,
  input  logic [W-1:0]        bus_wdata,
  input  logic [NT-1:0][W-1:0] cnt,
  input  logic [NT-1:0]       cause,
  input  logic [NT-1:0]       mask,
  output logic [NT-1:0]       en,
  output logic [NT-1:0]       rl_en,
  output logic [NT-1:0]       val_wr,
  output logic [NT-1:0][W-1:0] reload,
  output logic                cause_wr,
  output logic                mask_wr,
  output logic [W-1:0]        rdata
);
  localparam int CB = 2 * NT;

  logic [CB-1:0]       ctrl_q;
  logic                ctrl_wr;
  logic [NT-1:0]       rld_wr;
  logic [NT-1:0][W-1:0] reload_q;
  logic [W-1:0]        rd_d, rdata_q;

  assign ctrl_wr  = bus_wr && (bus_addr == OFS_CTRL);
  assign cause_wr = bus_wr && (bus_addr == OFS_CAUSE);
  assign mask_wr  = bus_wr && (bus_addr == OFS_MASK);

  genvar g;
  generate
    for (g = 0; g < NT; g++) begin : g_dec
      assign rld_wr[g] = bus_wr && (bus_addr == reload_ofs(g));
      assign val_wr[g] = bus_wr && (bus_addr == value_ofs(g));
      assign en[g]     = ctrl_q[2*g];
      assign rl_en[g]  = ctrl_q[2*g+1];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          reload_q[g] <= '0;
        end else if (rld_wr[g]) begin
          reload_q[g] <= bus_wdata;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= bus_wdata[CB-1:0];
    end
  end

  always_comb begin
    rd_d = '0;
    if (bus_addr == OFS_CTRL) begin
      rd_d[CB-1:0] = ctrl_q;
    end
    if (bus_addr == OFS_CAUSE) begin
      rd_d[CAUSE_LSB +: NT] = cause;
    end
    if (bus_addr == OFS_MASK) begin
      rd_d[CAUSE_LSB +: NT] = mask;
    end
    for (int i = 0; i < NT; i++) begin
      if (bus_addr == reload_ofs(i)) rd_d = reload_q[i];
      if (bus_addr == value_ofs(i))  rd_d = cnt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rd_d;
    end
  end

  assign reload = reload_q;
  assign rdata  = rdata_q;
endmodule

// File: rtl/dual_dtimer.sv
module dual_dtimer
  import dtm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [1:0]                       rst_sync_q;
  logic                             rst_n_s;
  logic [NUM_TMR-1:0]               t_en, t_rl, t_vwr, t_expire;
  logic [NUM_TMR-1:0][DATA_W-1:0]   t_cnt, t_reload;
  logic [NUM_TMR-1:0]               cause_q, mask_q;
  logic                             cause_wr, mask_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  dtm_regs #(.NT(NUM_TMR), .W(DATA_W), .AW(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .cnt      (t_cnt),
    .cause    (cause_q),
    .mask     (mask_q),
    .en       (t_en),
    .rl_en    (t_rl),
    .val_wr   (t_vwr),
    .reload   (t_reload),
    .cause_wr (cause_wr),
    .mask_wr  (mask_wr),
    .rdata    (bus_rdata)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_TMR; g++) begin : g_tmr
      dtm_counter #(.W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n_s),
        .tick      (tick),
        .en        (t_en[g]),
        .rl_en     (t_rl[g]),
        .load_wr   (t_vwr[g]),
        .load_val  (bus_wdata),
        .reload_val(t_reload[g]),
        .cnt       (t_cnt[g]),
        .expire    (t_expire[g])
      );
    end
  endgenerate

  dtm_intc #(.NT(NUM_TMR), .W(DATA_W), .LSB(CAUSE_LSB)) u_intc (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .expire  (t_expire),
    .cause_wr(cause_wr),
    .mask_wr (mask_wr),
    .wdata   (bus_wdata),
    .cause   (cause_q),
    .mask    (mask_q),
    .irq     (irq)
  );
endmodule

// File: rtl/dtm_checker.sv
module dtm_checker #(
  parameter int NT = 2,
  parameter int W  = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic [NT-1:0]        en,
  input logic [NT-1:0]        rl,
  input logic [NT-1:0]        vwr,
  input logic [NT-1:0]        expire,
  input logic [NT-1:0][W-1:0] cnt,
  input logic [NT-1:0][W-1:0] reload,
  input logic [NT-1:0]        cause,
  input logic [NT-1:0]        mask,
  input logic                 irq
);
  genvar g;
  generate
    for (g = 0; g < NT; g++) begin : g_chk
      AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en[g] && tick && cnt[g] != '0 && !vwr[g]) |=> (cnt[g] == $past(cnt[g]) - 1'b1)); // R2
      AST_CNT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en[g] && !vwr[g]) |=> $stable(cnt[g])); // R2
      AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (en[g] && rl[g] && tick && cnt[g] == '0 && !vwr[g]) |=> (cnt[g] == $past(reload[g]))); // R4
      AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en[g] && !rl[g] && cnt[g] == '0 && !vwr[g]) |=> (cnt[g] == '0)); // R5
      AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        expire[g] |=> cause[g]); // R3
    end
  endgenerate

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |=> !irq); // R8
  AST_IRQ_NOCAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == '0) |=> !irq); // R8
endmodule

bind dual_dtimer dtm_checker #(.NT(dtm_pkg::NUM_TMR), .W(dtm_pkg::DATA_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n_s),
  .tick  (tick),
  .en    (t_en),
  .rl    (t_rl),
  .vwr   (t_vwr),
  .expire(t_expire),
  .cnt   (t_cnt),
  .reload(t_reload),
  .cause (cause_q),
  .mask  (mask_q),
  .irq   (irq)
);

// File: tb/test_dual_dtimer.sv
module test_dual_dtimer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  dual_dtimer i_dual_dtimer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected value for each read issued
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (sb_q.size() > 0) begin
          item_t it;
          it = sb_q.pop_front();
          check(bus_rdata, it.exp, it.tag);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic tk = 1'b0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = tk;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    @(negedge clk);
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(12'h000, 32'h0, "R1 ctrl reset");
    rd(12'h010, 32'h0, "R1 reload0 reset");
    rd(12'h014, 32'h0, "R1 value0 reset");
    rd(12'h018, 32'h0, "R1 reload1 reset");
    rd(12'h01C, 32'h0, "R1 value1 reset");
    rd(12'h110, 32'h0, "R1 cause reset");
    rd(12'h114, 32'h0, "R1 mask reset");
    check({31'b0, irq}, 32'h0, "R1 irq reset");

    // one-shot on timer 0
    wr(12'h014, 32'd5);
    wr(12'h000, 32'h1);
    rd(12'h000, 32'h1, "R9 ctrl readback");
    ticks(3);
    rd(12'h014, 32'd2, "R2 decrement");
    wr(12'h000, 32'h0);
    ticks(4);
    rd(12'h014, 32'd2, "R2 frozen when disabled");
    wr(12'h000, 32'h1);
    ticks(2);
    rd(12'h014, 32'd0, "R2 reaches zero");
    rd(12'h110, 32'h0, "R3 no expiry before tick at zero");
    ticks(1);
    rd(12'h110, 32'h2, "R3 timer0 cause bit1");
    check({31'b0, irq}, 32'h0, "R8 masked irq low");
    ticks(5);
    rd(12'h014, 32'd0, "R5 one-shot holds zero");
    wr(12'h110, 32'hFFFF_FFFD);
    rd(12'h110, 32'h0, "R7 write0 clears");
    ticks(3);
    rd(12'h110, 32'h0, "R5 no further event");

    // periodic on timer 1
    wr(12'h018, 32'd3);
    wr(12'h01C, 32'd3);
    wr(12'h000, 32'hD);
    ticks(4);
    rd(12'h01C, 32'd3, "R4 reloaded after period");
    rd(12'h110, 32'h4, "R3 timer1 cause bit2");
    ticks(3);
    rd(12'h01C, 32'd0, "R4 period continues");
    wr(12'h014, 32'd0);
    ticks(1);
    rd(12'h01C, 32'd3, "R4 second reload");
    rd(12'h110, 32'h6, "R3 both causes");
    wr(12'h110, 32'hFFFF_FFFB);
    rd(12'h110, 32'h2, "R7 write1 keeps other bit");

    // mask and irq
    wr(12'h114, 32'hFFFF_FFFF);
    rd(12'h114, 32'h6, "R8 mask only bits 1 and 2");
    check({31'b0, irq}, 32'h1, "R8 irq asserted");
    wr(12'h114, 32'h4);
    @(negedge clk);
    check({31'b0, irq}, 32'h0, "R8 irq gated by mask");
    ticks(3);
    rd(12'h110, 32'h2, "R4 no event before zero tick");
    ticks(1);
    @(negedge clk);
    check({31'b0, irq}, 32'h1, "R8 irq from timer1");
    wr(12'h110, 32'h0);
    @(negedge clk);
    check({31'b0, irq}, 32'h0, "R7 irq drops after clear");

    // value write while enabled, and priority over tick
    wr(12'h01C, 32'd10);
    rd(12'h01C, 32'd10, "R6 direct load while enabled");
    ticks(1);
    rd(12'h01C, 32'd9, "R6 counting after load");
    wr(12'h01C, 32'd20, 1'b1);
    rd(12'h01C, 32'd20, "R6 write wins over tick");

    // free-running timer 0, timer 1 stopped
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h014, 32'hFFFF_FFFF);
    wr(12'h000, 32'h3);
    rd(12'h000, 32'h3, "R9 ctrl layout");
    ticks(3);
    rd(12'h014, ~32'd3, "R10 inverted value counts ticks");
    rd(12'h01C, 32'd20, "R2 timer1 frozen");

    // unmapped offsets
    rd(12'h004, 32'h0, "R1 unmapped 0x004");
    rd(12'h020, 32'h0, "R1 unmapped 0x020");
    rd(12'h118, 32'h0, "R1 unmapped 0x118");

    repeat (4) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule